// File: doc/BRIEF.md
# Interrupt-capable GPIO bank

This block is a bank of general-purpose lines behind a small register bus: an address, a write strobe, write data, and combinational read data. Each line works in one of three ways. As a general input, its pin is sampled through a two-stage synchroniser. As a general output, it drives a latched value with its output enable raised. As an interrupt input, its synchronised pin level feeds a per-line status bit.

Each interrupt line has its own settings. Sensing is by level or by edge. Polarity selects active-high/rising or active-low/falling. A further bit makes an edge-sensed line respond to any transition. Level status simply follows the pin. Edge status holds until software clears it. A per-line enable mask gates the status bits, and their OR drives a single interrupt request.

Software masks lines by writing zeros to the mask word. It enables lines by writing ones to a separate unmask word. Either way, lines that are not being changed stay as they are.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `pin_oe` is 0.
- R2: Bit i of `pin_oe` is 1 exactly when line i has mode bit 0 (offset 0x00, 1 = interrupt input) and direction bit 1 (offset 0x04, 1 = output). `pin_out` equals the output latch (offset 0x08).
- R3: Reading offset 0x0C returns the output latch bit for lines whose `pin_oe` is 1. For all other lines it returns the pin level after two clock stages.
- R4: A level-sensed interrupt line (mode 1, edge/level bit at 0x24 = 0) has status bit (offset 0x10) equal to pin XOR polarity (offset 0x20, 1 = active low). Writes to the clear word (offset 0x14) do not affect it.
- R5: An edge-sensed line (0x24 bit = 1) with both-edge bit (offset 0x4C) 0 latches status on a rising edge when polarity is 0, or on a falling edge when polarity is 1. The bit holds until a 1 is written to it at offset 0x14.
- R6: With the both-edge bit set, an edge-sensed line latches on either transition, whatever its polarity bit says.
- R7: When a new edge and a clear write for the same line reach the status register in the same cycle, the status bit ends up 1.
- R8: A write to offset 0x18 leaves each mask bit as old AND written. A write to offset 0x1C leaves each mask bit as old OR written. Offset 0x18 reads back the mask.
- R9: `irq` is 1 exactly when some line has both its status bit and its mask bit set.
- R10: Lines in general I/O mode (mode bit 0) never set a status bit.
- R11: Writes to offsets 0x0C and 0x10 change no register. Offsets 0x14, 0x1C and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data, one bit per line |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch values |
| pin_oe | output | 32 | Per-line output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong configuration bit shows up at the ports immediately. `pin_oe` changes on the cycle after the write, and the read path changes at the same moment. A wrong synchroniser or edge history appears three clock edges after a pin change, as a status bit that is missing or extra. A wrong mask or status bit shows on `irq` in that same cycle. A status bit that fails to hold is caught by reading it back many cycles later. The same is true of a clear that acts on level lines.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int OFS_W = 8;

    localparam logic [OFS_W-1:0] OFS_MODE   = 8'h00;
    localparam logic [OFS_W-1:0] OFS_DIR    = 8'h04;
    localparam logic [OFS_W-1:0] OFS_OUT    = 8'h08;
    localparam logic [OFS_W-1:0] OFS_IN     = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_STAT   = 8'h10;
    localparam logic [OFS_W-1:0] OFS_CLR    = 8'h14;
    localparam logic [OFS_W-1:0] OFS_MASK   = 8'h18;
    localparam logic [OFS_W-1:0] OFS_UNMASK = 8'h1C;
    localparam logic [OFS_W-1:0] OFS_POL    = 8'h20;
    localparam logic [OFS_W-1:0] OFS_EDGE   = 8'h24;
    localparam logic [OFS_W-1:0] OFS_BOTH   = 8'h4C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_DIR,
        SEL_OUT,
        SEL_IN,
        SEL_STAT,
        SEL_CLR,
        SEL_MASK,
        SEL_UNMASK,
        SEL_POL,
        SEL_EDGE,
        SEL_BOTH
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] a);
        case (a)
            OFS_MODE:   return SEL_MODE;
            OFS_DIR:    return SEL_DIR;
            OFS_OUT:    return SEL_OUT;
            OFS_IN:     return SEL_IN;
            OFS_STAT:   return SEL_STAT;
            OFS_CLR:    return SEL_CLR;
            OFS_MASK:   return SEL_MASK;
            OFS_UNMASK: return SEL_UNMASK;
            OFS_POL:    return SEL_POL;
            OFS_EDGE:   return SEL_EDGE;
            OFS_BOTH:   return SEL_BOTH;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_cfg.sv
module gpio_bank_cfg
    import gpio_bank_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic              we,
    input  logic [NLINES-1:0] wdata,
    output logic [NLINES-1:0] mode,
    output logic [NLINES-1:0] dir,
    output logic [NLINES-1:0] outv,
    output logic [NLINES-1:0] mask,
    output logic [NLINES-1:0] pol,
    output logic [NLINES-1:0] edg,
    output logic [NLINES-1:0] both,
    output logic [NLINES-1:0] clr
);

    typedef struct packed {
        logic [NLINES-1:0] mode;
        logic [NLINES-1:0] dir;
        logic [NLINES-1:0] outv;
        logic [NLINES-1:0] mask;
        logic [NLINES-1:0] pol;
        logic [NLINES-1:0] edg;
        logic [NLINES-1:0] both;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        clr   = '0;
        if (we) begin
            case (sel)
                SEL_MODE:   cfg_d.mode = wdata;
                SEL_DIR:    cfg_d.dir  = wdata;
                SEL_OUT:    cfg_d.outv = wdata;
                SEL_MASK:   cfg_d.mask = cfg_q.mask & wdata;
                SEL_UNMASK: cfg_d.mask = cfg_q.mask | wdata;
                SEL_POL:    cfg_d.pol  = wdata;
                SEL_EDGE:   cfg_d.edg  = wdata;
                SEL_BOTH:   cfg_d.both = wdata;
                SEL_CLR:    clr        = wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mode = cfg_q.mode;
    assign dir  = cfg_q.dir;
    assign outv = cfg_q.outv;
    assign mask = cfg_q.mask;
    assign pol  = cfg_q.pol;
    assign edg  = cfg_q.edg;
    assign both = cfg_q.both;

    // R8: writing all zeros to the mask word masks every line
    a_r8_mask_all_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_MASK && wdata == '0) |=> (mask == '0));

    // R11: a write to the input word leaves the output latch alone
    a_r11_in_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_IN) |=> $stable(outv));

endmodule

// File: rtl/gpio_bank_sense.sv
module gpio_bank_sense #(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] pin_s,
    input  logic [NLINES-1:0] mode,
    input  logic [NLINES-1:0] edg,
    input  logic [NLINES-1:0] pol,
    input  logic [NLINES-1:0] both,
    input  logic [NLINES-1:0] clr,
    output logic [NLINES-1:0] status
);

    typedef struct packed {
        logic [NLINES-1:0] prev;
        logic [NLINES-1:0] stat;
    } sense_t;

    sense_t st_d, st_q;
    logic [NLINES-1:0] rise_w, fall_w, hit_w, level_w, latched_w;

    always_comb begin
        rise_w    = pin_s & ~st_q.prev;
        fall_w    = ~pin_s & st_q.prev;
        hit_w     = (both & (rise_w | fall_w))
                  | (~both & pol & fall_w)
                  | (~both & ~pol & rise_w);
        level_w   = mode & (pin_s ^ pol);
        latched_w = (st_q.stat & ~clr) | (mode & hit_w);
        st_d.prev = pin_s;
        st_d.stat = (edg & latched_w) | (~edg & level_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.stat;

    // R5: a latched edge bit survives any cycle without a clear for it
    a_r5_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & $past(edg) & ~$past(clr) & ~status) == '0));

    // R10: level lines in general I/O mode never carry status
    a_r10_io_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(mode) & ~$past(edg)) == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_we,
    input  logic [NLINES-1:0] bus_wdata,
    output logic [NLINES-1:0] bus_rdata,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pin_out,
    output logic [NLINES-1:0] pin_oe,
    output logic              irq
);

    localparam int SYNC_STAGES = 2;

    reg_sel_e          sel;
    logic [NLINES-1:0] mode, dir, outv, mask, pol, edg, both, clr;
    logic [NLINES-1:0] pin_s, status, rd_in;

    assign sel = decode_ofs(bus_addr);

    gpio_bank_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_s)
    );

    gpio_bank_cfg #(.NLINES(NLINES)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .we    (bus_we),
        .wdata (bus_wdata),
        .mode  (mode),
        .dir   (dir),
        .outv  (outv),
        .mask  (mask),
        .pol   (pol),
        .edg   (edg),
        .both  (both),
        .clr   (clr)
    );

    gpio_bank_sense #(.NLINES(NLINES)) u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_s  (pin_s),
        .mode   (mode),
        .edg    (edg),
        .pol    (pol),
        .both   (both),
        .clr    (clr),
        .status (status)
    );

    assign pin_oe  = dir & ~mode;
    assign pin_out = outv;
    assign rd_in   = (pin_oe & outv) | (~pin_oe & pin_s);
    assign irq     = |(status & mask);

    always_comb begin
        case (sel)
            SEL_MODE: bus_rdata = mode;
            SEL_DIR:  bus_rdata = dir;
            SEL_OUT:  bus_rdata = outv;
            SEL_IN:   bus_rdata = rd_in;
            SEL_STAT: bus_rdata = status;
            SEL_MASK: bus_rdata = mask;
            SEL_POL:  bus_rdata = pol;
            SEL_EDGE: bus_rdata = edg;
            SEL_BOTH: bus_rdata = both;
            default:  bus_rdata = '0;
        endcase
    end

    // R2: an interrupt-mode line never drives its pin
    a_r2_no_drive_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & mode) == '0));

    // R9: the request needs at least one enabled status bit
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($countones(status & mask) > 0));

endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int total = 0;
    int bad = 0;

    gpio_irq_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] edge_hit(input logic [31:0] p0, p1, pol, both);
        return (both & (p0 ^ p1)) | (~both & pol & p0 & ~p1) | (~both & ~pol & ~p0 & p1);
    endfunction

    initial begin
        #3_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] p0, p1, md, dr, ov, pl, eg, bt, mk, exp_s, oe;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        foreach (u0.bus_rdata[i]) begin end
        rd(8'h00, v); chk("R1 mode", v, 0);
        rd(8'h04, v); chk("R1 dir", v, 0);
        rd(8'h08, v); chk("R1 out", v, 0);
        rd(8'h10, v); chk("R1 status", v, 0);
        rd(8'h18, v); chk("R1 mask", v, 0);
        rd(8'h4C, v); chk("R1 both", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 oe", pin_oe, 0);

        // R2 direction and output latch
        wr(8'h08, 32'h0000_00A5);
        wr(8'h04, 32'h0000_00FF);
        chk("R2 oe", pin_oe, 32'h0000_00FF);
        chk("R2 out", pin_out, 32'h0000_00A5);
        wr(8'h00, 32'h0000_0001);
        chk("R2 oe irq-mode", pin_oe, 32'h0000_00FE);

        // R3 input read mixes latch and pins
        pin_in = 32'h1234_565A;
        settle();
        rd(8'h0C, v); chk("R3 in", v, 32'h1234_56A4);

        // R11 read-only writes and unmapped reads
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h08, v); chk("R11 out after in-write", v, 32'h0000_00A5);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R11 status after write", v, 0);
        rd(8'h30, v); chk("R11 unmapped", v, 0);
        rd(8'h1C, v); chk("R11 unmask reads 0", v, 0);

        // R4 level sensing ignores clear
        wr(8'h04, 0);
        wr(8'h20, 32'h0000_FF00);
        wr(8'h00, 32'hFFFF_FFFF);
        pin_in = 32'h0F0F_0F0F;
        settle();
        rd(8'h10, v); chk("R4 level", v, 32'h0F0F_F00F);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R4 clear ignored", v, 32'h0F0F_F00F);

        // R8 mask set/clear words, R9 irq
        wr(8'h1C, 32'h0000_FFFF);
        wr(8'h18, 32'hFFFF_FF00);
        rd(8'h18, v); chk("R8 mask", v, 32'h0000_FF00);
        @(negedge clk); chk("R9 irq on", {31'd0, irq}, 1);
        wr(8'h18, 32'hFFFF_00FF);
        @(negedge clk); chk("R9 irq off", {31'd0, irq}, 0);

        // R7 clear and new edge in the same cycle
        wr(8'h20, 0);
        wr(8'h24, 32'hFFFF_FFFF);
        pin_in = 0;
        settle();
        wr(8'h14, 32'hFFFF_FFFF);
        @(negedge clk);
        pin_in = 32'h0000_0001;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 8'h14; bus_we = 1'b1; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_we = 1'b0;
        rd(8'h10, v); chk("R7 edge beats clear", v, 32'h0000_0001);

        // R5 hold until clear
        repeat (10) @(negedge clk);
        rd(8'h10, v); chk("R5 edge held", v, 32'h0000_0001);
        wr(8'h14, 32'h0000_0001);
        rd(8'h10, v); chk("R5 edge cleared", v, 0);

        // R6 both edges on a falling transition with positive polarity
        wr(8'h4C, 32'h0000_0001);
        pin_in = 0;
        settle();
        rd(8'h10, v); chk("R6 both falling", v, 32'h0000_0001);

        // random mix: R2 R3 R4 R5 R6 R9 R10
        for (int it = 0; it < 60; it++) begin
            p0 = $urandom; p1 = $urandom;
            md = $urandom; dr = $urandom; ov = $urandom;
            pl = $urandom; eg = $urandom; bt = $urandom; mk = $urandom;
            pin_in = p0;
            wr(8'h00, md); wr(8'h04, dr); wr(8'h08, ov);
            wr(8'h20, pl); wr(8'h24, eg); wr(8'h4C, bt);
            settle();
            wr(8'h14, 32'hFFFF_FFFF);
            wr(8'h18, 0); wr(8'h1C, mk);
            pin_in = p1;
            settle();
            exp_s = (md & ~eg & (p1 ^ pl)) | (md & eg & edge_hit(p0, p1, pl, bt));
            oe = dr & ~md;
            chk("R2 rand oe", pin_oe, oe);
            rd(8'h10, v); chk("R4 R5 R6 R10 rand status", v, exp_s);
            rd(8'h0C, v); chk("R3 rand in", v, (oe & ov) | (~oe & p1));
            chk("R9 rand irq", {31'd0, irq}, {31'd0, |(exp_s & mk)});
        end

        // R10 I/O mode lines stay silent across toggles
        wr(8'h00, 0);
        wr(8'h14, 32'hFFFF_FFFF);
        pin_in = ~pin_in;
        settle();
        rd(8'h10, v); chk("R10 io quiet", v, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule